// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit CPU bus and a cartridge ROM and battery-backed RAM. The ROM occupies CPU addresses 0x0000–0x7FFF. CPU writes into that space store no data. Instead they load control registers: an external-RAM enable, a ROM bank number, a two-bit upper register and a mode bit.

From these registers and the CPU address, the block forms a physical ROM address and a physical RAM address. It also produces a gated RAM write strobe and a read-data multiplexer that returns 0xFF whenever RAM is switched off. The 16 KiB window at 0x4000–0x7FFF follows the selected ROM bank. The 8 KiB window at 0xA000–0xBFFF follows the selected RAM bank.

The ROM size is set by a parameter that counts 16 KiB banks. A bank number that selects past the end of the ROM is wrapped by masking.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A CPU write with cpuAddr[15]=0 loads a control register chosen by cpuAddr[14:13]: 00 RAM enable, 01 low bank, 10 upper register, 11 mode. The new state governs the outputs from the first clock edge at which cpuWrEn is sampled high. Writes with cpuAddr[15]=1 leave every control register unchanged.
- R2: Writing 0x0A to the RAM-enable region switches RAM on. Writing 0x00 switches it off. Any other value leaves the enable as it was.
- R3: A low-bank write replaces ROM bank bits 4:0 with cpuWrData[4:0], using 1 in place of a zero value. ROM bank bits 6:5 are kept.
- R4: An upper-register write loads cpuWrData[1:0] into ROM bank bits 6:5 when the mode is 0, and into the RAM bank when the mode is 1. In mode 1 the ROM bank does not change.
- R5: A mode write stores cpuWrData[0] as the mode. Writing 1 clears ROM bank bits 6:5. Writing 0 sets the RAM bank to 0.
- R6: Every ROM bank value that is stored is ANDed with ROM_BANKS-1, where ROM_BANKS is a power of two from 2 to 128.
- R7: romAddr is {0, cpuAddr[13:0]} when cpuAddr[15:14]=00. It is {bank[log2(ROM_BANKS)-1:0], cpuAddr[13:0]} when cpuAddr[15:14]=01.
- R8: ramAddr is {ramBank, cpuAddr[12:0]}. ramWrEn is high only when cpuWrEn is high, cpuAddr[15:13]=101 and RAM is on.
- R9: cpuRdData carries romRdData in 0x0000–0x7FFF. In 0xA000–0xBFFF it carries ramRdData when RAM is on and 0xFF when RAM is off. Elsewhere it is 0xFF.
- R10: After reset the ROM bank is 1, the RAM bank is 0, the mode is 0 and RAM is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuWrEn | input | 1 | CPU write strobe, one cycle per write |
| romRdData | input | 8 | Data from the ROM device |
| ramRdData | input | 8 | Data from the RAM device |
| romAddr | output | 14+log2(ROM_BANKS) | Physical ROM address |
| ramAddr | output | 15 | Physical RAM address |
| ramWrEn | output | 1 | Gated RAM write enable |
| cpuRdData | output | 8 | Read data returned to the CPU |

## Verification
Register writes take effect at the single clock edge that samples cpuWrEn. Every address and read-data output is combinational from the registers and the current CPU address. Each bench write therefore drives the bus at a falling edge and drops the strobe at the next falling edge. The bench then sets a probe address and samples one time step later, still well before the next rising edge. The effect of each write is thus observed exactly one edge after it was issued. ramWrEn is checked in the same cycle as the write that drives it.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int BANK_REG_W = 7;
  localparam int RAM_BANK_W = 2;
  localparam int RAM_WIN_W  = 13;
  localparam int ROM_WIN_W  = 14;
  localparam logic [7:0] RAM_ON_CODE  = 8'h0A;
  localparam logic [7:0] RAM_OFF_CODE = 8'h00;
  localparam logic [7:0] OPEN_BUS     = 8'hFF;

  typedef enum logic [1:0] {
    REG_RAM_EN = 2'b00,
    REG_BANK_LO = 2'b01,
    REG_UPPER  = 2'b10,
    REG_MODE   = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic ramEnSet;
    logic ramEnClr;
    logic bankLoWr;
    logic upperWr;
    logic modeWr;
    logic romWin;
    logic romHiWin;
    logic ramWin;
    logic ramWrReq;
  } strobe_t;
endpackage

// File: rtl/cbc_ctrl.sv
module cbc_ctrl
  import cbc_pkg::*;
(
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuWrData,
  input  logic        cpuWrEn,
  output strobe_t     stb
);
  logic     regWr;
  reg_sel_e regSel;

  always_comb begin
    regWr  = cpuWrEn && !cpuAddr[15];
    regSel = reg_sel_e'(cpuAddr[14:13]);
    stb = '0;
    stb.ramEnSet = regWr && (regSel == REG_RAM_EN) && (cpuWrData == RAM_ON_CODE);
    stb.ramEnClr = regWr && (regSel == REG_RAM_EN) && (cpuWrData == RAM_OFF_CODE);
    stb.bankLoWr = regWr && (regSel == REG_BANK_LO);
    stb.upperWr  = regWr && (regSel == REG_UPPER);
    stb.modeWr   = regWr && (regSel == REG_MODE);
    stb.romWin   = !cpuAddr[15];
    stb.romHiWin = (cpuAddr[15:14] == 2'b01);
    stb.ramWin   = (cpuAddr[15:13] == 3'b101);
    stb.ramWrReq = cpuWrEn && (cpuAddr[15:13] == 3'b101);
  end
endmodule

// File: rtl/cbc_datapath.sv
module cbc_datapath
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  localparam int BANK_W = $clog2(ROM_BANKS),
  localparam int ROM_AW = ROM_WIN_W + BANK_W,
  localparam int RAM_AW = RAM_WIN_W + RAM_BANK_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [4:0]            wrBits,
  input  logic [ROM_WIN_W-1:0]  winOffset,
  input  logic [7:0]            romRdData,
  input  logic [7:0]            ramRdData,
  output logic [ROM_AW-1:0]     romAddr,
  output logic [RAM_AW-1:0]     ramAddr,
  output logic                  ramWrEn,
  output logic [7:0]            cpuRdData,
  output logic [BANK_REG_W-1:0] romBankQ,
  output logic [RAM_BANK_W-1:0] ramBankQ,
  output logic                  modeQ,
  output logic                  ramOnQ
);
  localparam logic [BANK_REG_W-1:0] BANK_MASK = BANK_REG_W'(ROM_BANKS - 1);
  localparam logic [BANK_REG_W-1:0] RESET_BANK = BANK_REG_W'(1) & BANK_MASK;

  logic [BANK_REG_W-1:0] romBankD;
  logic [RAM_BANK_W-1:0] ramBankD;
  logic                  modeD;
  logic                  ramOnD;
  logic [4:0]            loBits;

  always_comb begin
    romBankD = romBankQ;
    ramBankD = ramBankQ;
    modeD    = modeQ;
    ramOnD   = ramOnQ;
    loBits   = (wrBits == 5'd0) ? 5'd1 : wrBits;
    if (stb.ramEnSet) ramOnD = 1'b1;
    else if (stb.ramEnClr) ramOnD = 1'b0;
    if (stb.bankLoWr) romBankD = {romBankQ[6:5], loBits} & BANK_MASK;
    if (stb.upperWr) begin
      if (!modeQ) romBankD = {wrBits[1:0], romBankQ[4:0]} & BANK_MASK;
      else        ramBankD = wrBits[1:0];
    end
    if (stb.modeWr) begin
      modeD = wrBits[0];
      if (wrBits[0]) romBankD = {2'b00, romBankQ[4:0]} & BANK_MASK;
      else           ramBankD = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romBankQ <= RESET_BANK;
      ramBankQ <= '0;
      modeQ    <= 1'b0;
      ramOnQ   <= 1'b0;
    end else begin
      romBankQ <= romBankD;
      ramBankQ <= ramBankD;
      modeQ    <= modeD;
      ramOnQ   <= ramOnD;
    end
  end

  always_comb begin
    romAddr = stb.romHiWin ? {romBankQ[BANK_W-1:0], winOffset}
                           : {{BANK_W{1'b0}}, winOffset};
    ramAddr = {ramBankQ, winOffset[RAM_WIN_W-1:0]};
    ramWrEn = stb.ramWrReq && ramOnQ;
    if (stb.romWin)                cpuRdData = romRdData;
    else if (stb.ramWin && ramOnQ) cpuRdData = ramRdData;
    else                           cpuRdData = OPEN_BUS;
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  localparam int ROM_AW = ROM_WIN_W + $clog2(ROM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        cpuWrData,
  input  logic              cpuWrEn,
  input  logic [7:0]        romRdData,
  input  logic [7:0]        ramRdData,
  output logic [ROM_AW-1:0] romAddr,
  output logic [14:0]       ramAddr,
  output logic              ramWrEn,
  output logic [7:0]        cpuRdData
);
  strobe_t               stb;
  logic [BANK_REG_W-1:0] romBankQ;
  logic [RAM_BANK_W-1:0] ramBankQ;
  logic                  modeQ;
  logic                  ramOnQ;

  cbc_ctrl u_ctrl (
    .cpuAddr  (cpuAddr),
    .cpuWrData(cpuWrData),
    .cpuWrEn  (cpuWrEn),
    .stb      (stb)
  );

  cbc_datapath #(.ROM_BANKS(ROM_BANKS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrBits   (cpuWrData[4:0]),
    .winOffset(cpuAddr[ROM_WIN_W-1:0]),
    .romRdData(romRdData),
    .ramRdData(ramRdData),
    .romAddr  (romAddr),
    .ramAddr  (ramAddr),
    .ramWrEn  (ramWrEn),
    .cpuRdData(cpuRdData),
    .romBankQ (romBankQ),
    .ramBankQ (ramBankQ),
    .modeQ    (modeQ),
    .ramOnQ   (ramOnQ)
  );
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int ROM_BANKS = 64
) (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] cpuAddr,
  input logic [7:0]  cpuWrData,
  input logic        cpuWrEn,
  input logic [6:0]  romBankQ,
  input logic [1:0]  ramBankQ,
  input logic        modeQ,
  input logic        ramOnQ
);
  logic regWr;
  assign regWr = cpuWrEn && !cpuAddr[15];

  p_ram_on_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && cpuAddr[14:13] == 2'b00 && cpuWrData == 8'h0A) |=> ramOnQ);

  p_ram_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && cpuAddr[14:13] == 2'b00 && cpuWrData == 8'h00) |=> !ramOnQ);

  p_ram_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && cpuAddr[14:13] == 2'b00 && cpuWrData != 8'h0A && cpuWrData != 8'h00)
    |=> $stable(ramOnQ));

  p_lo_keeps_hi_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && cpuAddr[14:13] == 2'b01) |=> romBankQ[6:5] == $past(romBankQ[6:5]));

  p_mode1_rom_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && cpuAddr[14:13] == 2'b10 && modeQ) |=> $stable(romBankQ));

  p_mode0_ram_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && cpuAddr[14:13] == 2'b11 && !cpuWrData[0]) |=> (ramBankQ == 2'd0 && !modeQ));

  p_bank_in_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    32'(romBankQ) < ROM_BANKS);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !regWr |=> ($stable(romBankQ) && $stable(ramBankQ) && $stable(modeQ) && $stable(ramOnQ)));
endmodule

bind cart_bank_ctrl cbc_checker #(.ROM_BANKS(ROM_BANKS)) u_cbc_checker (
  .clk      (clk),
  .rstN     (rstN),
  .cpuAddr  (cpuAddr),
  .cpuWrData(cpuWrData),
  .cpuWrEn  (cpuWrEn),
  .romBankQ (romBankQ),
  .ramBankQ (ramBankQ),
  .modeQ    (modeQ),
  .ramOnQ   (ramOnQ)
);

// File: tb/test_cart_bank_ctrl.sv
`timescale 1ns/1ps
module test_cart_bank_ctrl;
  localparam int BANKS = 64;
  localparam int AW = 20;
  localparam logic [6:0] MASK = 7'(BANKS - 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [15:0]   cpuAddr = '0;
  logic [7:0]    cpuWrData = '0;
  logic          cpuWrEn = 1'b0;
  logic [7:0]    romRdData = 8'h5A;
  logic [7:0]    ramRdData = 8'h3C;
  logic [AW-1:0] romAddr;
  logic [14:0]   ramAddr;
  logic          ramWrEn;
  logic [7:0]    cpuRdData;

  int checks = 0;
  int errors = 0;

  logic [6:0] mBank;
  logic [1:0] mRam;
  logic       mMode;
  logic       mOn;

  always #5 clk = ~clk;

  cart_bank_ctrl #(.ROM_BANKS(BANKS)) i_cart_bank_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWrEn(cpuWrEn), .romRdData(romRdData), .ramRdData(ramRdData),
    .romAddr(romAddr), .ramAddr(ramAddr), .ramWrEn(ramWrEn), .cpuRdData(cpuRdData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    logic [4:0] lo;
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWrEn = 1'b1;
    @(negedge clk);
    cpuWrEn = 1'b0;
    if (!a[15]) begin
      case (a[14:13])
        2'b00: if (d == 8'h0A) mOn = 1'b1; else if (d == 8'h00) mOn = 1'b0;
        2'b01: begin
          lo = (d[4:0] == 5'd0) ? 5'd1 : d[4:0];
          mBank = {mBank[6:5], lo} & MASK;
        end
        2'b10: if (!mMode) mBank = {d[1:0], mBank[4:0]} & MASK; else mRam = d[1:0];
        default: begin
          mMode = d[0];
          if (d[0]) mBank = {2'b00, mBank[4:0]} & MASK; else mRam = 2'd0;
        end
      endcase
    end
  endtask

  task automatic probeRom(input logic [15:0] a, input string req);
    logic [AW-1:0] exp;
    cpuAddr = a; #1;
    exp = a[14] ? {mBank[5:0], a[13:0]} : {6'd0, a[13:0]};
    check(romAddr == exp && cpuRdData == 8'h5A, req, int'(romAddr), int'(exp));
  endtask

  task automatic probeRam(input logic [15:0] a, input string req);
    logic [14:0] exp;
    logic [7:0]  expRd;
    cpuAddr = a; #1;
    exp = {mRam, a[12:0]};
    expRd = mOn ? 8'h3C : 8'hFF;
    check(ramAddr == exp, req, int'(ramAddr), int'(exp));
    check(cpuRdData == expRd, req, int'(cpuRdData), int'(expRd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mBank = 7'd1; mRam = 2'd0; mMode = 1'b0; mOn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state, R7 fixed window
    probeRom(16'h4000, "R10 reset bank");
    probeRom(16'h1234, "R7 fixed window");
    probeRam(16'hA010, "R10 reset ram off");
    // R3 R4 R6 sweep in mode 0
    for (int hi = 0; hi < 4; hi++) begin
      for (int lo = 0; lo < 32; lo++) begin
        busWrite(16'h4000 | 16'(hi * 16'h0123), 8'(hi) | 8'hE0);
        busWrite(16'h2000 | 16'(lo * 16'h00F1), 8'(lo) | 8'hA0);
        probeRom(16'h4000 | 16'((lo * 16'h0255) & 16'h3FFF), "R3 R4 R6 mode0 bank");
      end
    end
    // R2 enable values
    busWrite(16'h0000, 8'h0A);
    probeRam(16'hA123, "R2 enable");
    busWrite(16'h1FFF, 8'h55);
    probeRam(16'hBFFF, "R2 other value ignored");
    @(negedge clk); cpuAddr = 16'hA005; cpuWrEn = 1'b1; #1;
    check(ramWrEn == 1'b1, "R8 ramWrEn on", int'(ramWrEn), 1);
    cpuWrEn = 1'b0;
    busWrite(16'h0100, 8'h00);
    probeRam(16'hA000, "R2 disable");
    @(negedge clk); cpuAddr = 16'hA005; cpuWrEn = 1'b1; #1;
    check(ramWrEn == 1'b0, "R8 ramWrEn gated", int'(ramWrEn), 0);
    cpuWrEn = 1'b0;
    busWrite(16'h0000, 8'h0A);
    @(negedge clk); cpuAddr = 16'h8005; cpuWrEn = 1'b1; #1;
    check(ramWrEn == 1'b0, "R8 ramWrEn outside window", int'(ramWrEn), 0);
    cpuWrEn = 1'b0;
    cpuAddr = 16'hC000; #1;
    check(cpuRdData == 8'hFF, "R9 open bus", int'(cpuRdData), 8'hFF);
    // R5 mode 1 and R4 RAM bank routing
    busWrite(16'h4000, 8'h03);
    busWrite(16'h2000, 8'h17);
    busWrite(16'h6000, 8'h01);
    probeRom(16'h7FFF, "R5 mode1 clears high bits");
    for (int rb = 0; rb < 4; rb++) begin
      busWrite(16'h5000, 8'(rb));
      probeRam(16'hA000 | 16'(rb * 16'h0777 & 16'h1FFF), "R4 mode1 ram bank");
      probeRom(16'h4ABC, "R4 mode1 rom unchanged");
    end
    // R1 writes above 0x7FFF do nothing
    busWrite(16'h8000, 8'h00);
    busWrite(16'hA000, 8'h00);
    busWrite(16'hC000, 8'h1F);
    probeRam(16'hA001, "R1 high writes ignored");
    probeRom(16'h4001, "R1 high writes ignored");
    // R5 mode 0 resets RAM bank
    busWrite(16'h7000, 8'hFE);
    probeRam(16'hA002, "R5 mode0 ram bank zero");
    busWrite(16'h4000, 8'h02);
    probeRom(16'h6000, "R4 mode0 upper again");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule